// File: doc/BRIEF.md
# Byte-Parity Registered Transceiver

This block moves a 16-bit word between an A side and a B side. Each side carries two bytes, and each byte has its own parity bit. Each direction has its own storage stage with its own clock, latch enable and output enable. The stage can pass data straight through, capture it on the rising edge of its clock, or hold it while that clock stays idle. The two directions work independently of each other, except for the odd/even select, which they share.

The A-to-B path has two modes. In generate mode it computes a fresh parity bit for each outgoing byte. In check mode it forwards the incoming parity bits and checks them. The B-to-A path always forwards and checks. Each direction reports a single error flag, which covers both of its bytes. The flag is modelled as an open-drain pull-down request, so flags from several sources can be wire-ORed. The flag is gated by that direction's output enable, so a host can mask it while data settles. Tri-state outputs are modelled as a data vector plus a separate output-enable signal.

Top module: `bp_xcvr`

## Requirements
- R1: With a direction's latch enable high, its data and parity outputs follow its data and parity inputs in the same cycle, with no clock edge needed.
- R2: With the latch enable low, a direction's outputs show the word captured at the most recent rising edge of that direction's clock. They keep that word while the clock stays idle, even if the inputs change.
- R3: In A-to-B generate mode (`gen_sel`=1), each B parity bit `b_par_out[i]` covers byte i, which is bits 8i+7..8i. The bit is set so that the byte plus its parity bit holds an odd count of ones when `odd_sel`=1, or an even count when `odd_sel`=0. In this mode `err_ab_pull` is never asserted.
- R4: In A-to-B check mode (`gen_sel`=0), `b_par_out` is the stored or passed A parity. `err_ab_pull` is 1 when the output is enabled and at least one byte fails the parity rule of R3.
- R5: The B-to-A path never generates parity. `a_par_out` is always the stored or passed B parity. `err_ba_pull` is 1 when the output is enabled and at least one byte fails the parity rule.
- R6: The single `odd_sel` input sets the parity sense of both directions at once. Flipping it inverts the verdict on each byte in both directions.
- R7: While a direction's output enable is low, its data and parity outputs are 0, its port enable output is 0, and its error flag is 0.
- R8: An active-low `rst_n` clears the stored word and the stored parity of both directions to zero.
- R9: Clocking one direction leaves the stored contents of the other direction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both storage stages |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity, shared by both directions |
| clk_ab | input | 1 | A-to-B capture clock |
| le_ab | input | 1 | A-to-B latch enable, high = transparent |
| oe_ab | input | 1 | A-to-B output enable, active high |
| gen_sel | input | 1 | A-to-B mode: 1 = generate parity, 0 = check parity |
| a_in | input | 16 | Data arriving on the A side |
| a_par_in | input | 2 | Per-byte parity arriving on the A side |
| b_out | output | 16 | Data driven onto the B side |
| b_par_out | output | 2 | Per-byte parity driven onto the B side |
| b_oe | output | 1 | B-side drive enable |
| err_ab_pull | output | 1 | A-to-B error: 1 = pull the shared flag line low |
| clk_ba | input | 1 | B-to-A capture clock |
| le_ba | input | 1 | B-to-A latch enable, high = transparent |
| oe_ba | input | 1 | B-to-A output enable, active high |
| b_in | input | 16 | Data arriving on the B side |
| b_par_in | input | 2 | Per-byte parity arriving on the B side |
| a_out | output | 16 | Data driven onto the A side |
| a_par_out | output | 2 | Per-byte parity driven onto the A side |
| a_oe | output | 1 | A-side drive enable |
| err_ba_pull | output | 1 | B-to-A error: 1 = pull the shared flag line low |

## Verification
The assertions are sampled only on the two direction clocks. They therefore assume that data, mode and enable inputs are steady around each clock pulse. The bench meets this by changing inputs only while both clocks are low and then waiting before any pulse. The clocked-capture property also assumes that the previous edge of the same clock came after reset. A tracking bit in the checker supplies that guarantee, so the property is not applied to the first edge after reset.

// File: rtl/bp_xcvr.sv
module bp_xcvr #(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 2
) (
  input  logic                      rst_n,
  input  logic                      odd_sel,
  input  logic                      clk_ab,
  input  logic                      le_ab,
  input  logic                      oe_ab,
  input  logic                      gen_sel,
  input  logic [BYTES*BYTE_W-1:0]   a_in,
  input  logic [BYTES-1:0]          a_par_in,
  output logic [BYTES*BYTE_W-1:0]   b_out,
  output logic [BYTES-1:0]          b_par_out,
  output logic                      b_oe,
  output logic                      err_ab_pull,
  input  logic                      clk_ba,
  input  logic                      le_ba,
  input  logic                      oe_ba,
  input  logic [BYTES*BYTE_W-1:0]   b_in,
  input  logic [BYTES-1:0]          b_par_in,
  output logic [BYTES*BYTE_W-1:0]   a_out,
  output logic [BYTES-1:0]          a_par_out,
  output logic                      a_oe,
  output logic                      err_ba_pull
);
  localparam int W = BYTES * BYTE_W;

  logic [W-1:0]     ab_q, ba_q;
  logic [BYTES-1:0] ab_qp, ba_qp;
  logic [W-1:0]     ab_d, ba_d;
  logic [BYTES-1:0] ab_p, ba_p;
  logic [BYTES-1:0] ab_gen, ab_mis, ba_mis;

  always_ff @(posedge clk_ab or negedge rst_n) begin
    if (!rst_n) begin
      ab_q  <= '0;
      ab_qp <= '0;
    end else begin
      ab_q  <= a_in;
      ab_qp <= a_par_in;
    end
  end

  always_ff @(posedge clk_ba or negedge rst_n) begin
    if (!rst_n) begin
      ba_q  <= '0;
      ba_qp <= '0;
    end else begin
      ba_q  <= b_in;
      ba_qp <= b_par_in;
    end
  end

  assign ab_d = le_ab ? a_in     : ab_q;
  assign ab_p = le_ab ? a_par_in : ab_qp;
  assign ba_d = le_ba ? b_in     : ba_q;
  assign ba_p = le_ba ? b_par_in : ba_qp;

  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    assign ab_gen[i] = (^ab_d[i*BYTE_W +: BYTE_W]) ^ odd_sel;
    assign ab_mis[i] = (^{ab_d[i*BYTE_W +: BYTE_W], ab_p[i]}) != odd_sel;
    assign ba_mis[i] = (^{ba_d[i*BYTE_W +: BYTE_W], ba_p[i]}) != odd_sel;
  end

  assign b_oe        = oe_ab;
  assign b_out       = oe_ab ? ab_d : '0;
  assign b_par_out   = oe_ab ? (gen_sel ? ab_gen : ab_p) : '0;
  assign err_ab_pull = oe_ab && !gen_sel && (|ab_mis);

  assign a_oe        = oe_ba;
  assign a_out       = oe_ba ? ba_d : '0;
  assign a_par_out   = oe_ba ? ba_p : '0;
  assign err_ba_pull = oe_ba && (|ba_mis);
endmodule

// File: rtl/bp_xcvr_chk.sv
module bp_xcvr_chk #(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 2
) (
  input logic                    rst_n,
  input logic                    odd_sel,
  input logic                    clk_ab,
  input logic                    le_ab,
  input logic                    oe_ab,
  input logic                    gen_sel,
  input logic [BYTES*BYTE_W-1:0] a_in,
  input logic [BYTES*BYTE_W-1:0] b_out,
  input logic [BYTES-1:0]        b_par_out,
  input logic                    b_oe,
  input logic                    err_ab_pull,
  input logic                    clk_ba,
  input logic                    le_ba,
  input logic                    oe_ba,
  input logic [BYTES*BYTE_W-1:0] b_in,
  input logic [BYTES-1:0]        b_par_in,
  input logic [BYTES*BYTE_W-1:0] a_out,
  input logic [BYTES-1:0]        a_par_out,
  input logic                    a_oe,
  input logic                    err_ba_pull
);
  logic ab_seen;

  always_ff @(posedge clk_ab or negedge rst_n) begin
    if (!rst_n) ab_seen <= 1'b0;
    else        ab_seen <= 1'b1;
  end

  AST_AB_CLOCKED_CAPTURE: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (ab_seen && oe_ab && !le_ab) |-> (b_out == $past(a_in)));                         // R2

  AST_AB_GEN_NO_FLAG: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (gen_sel && oe_ab) |-> !err_ab_pull);                                              // R3

  for (genvar i = 0; i < BYTES; i++) begin : g_gen
    AST_AB_GEN_PARITY_OK: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (gen_sel && oe_ab) |-> ((^{b_out[i*BYTE_W +: BYTE_W], b_par_out[i]}) == odd_sel)); // R3
  end

  AST_AB_RELEASE: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !oe_ab |-> (!b_oe && !err_ab_pull && b_out == '0));                              // R7

  AST_BA_TRANSPARENT: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (le_ba && oe_ba) |-> (a_out == b_in && a_par_out == b_par_in));                    // R1

  AST_BA_RELEASE: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !oe_ba |-> (!a_oe && !err_ba_pull && a_out == '0 && a_par_out == '0));            // R7
endmodule

bind bp_xcvr bp_xcvr_chk #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_chk (.*);

// File: tb/bp_xcvr_bench.sv
module bp_xcvr_bench;
  logic clk = 1'b0;
  logic rst_n, odd_sel;
  logic clk_ab, le_ab, oe_ab, gen_sel;
  logic [15:0] a_in;
  logic [1:0]  a_par_in;
  logic [15:0] b_out;
  logic [1:0]  b_par_out;
  logic        b_oe, err_ab_pull;
  logic clk_ba, le_ba, oe_ba;
  logic [15:0] b_in;
  logic [1:0]  b_par_in;
  logic [15:0] a_out;
  logic [1:0]  a_par_out;
  logic        a_oe, err_ba_pull;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bp_xcvr u_bp_xcvr (.*);

  // {a_in, a_par_in, gen_sel, odd_sel, expected b_par_out, expected err_ab_pull}
  localparam logic [22:0] VEC [0:9] = '{
    {16'h0000, 2'b00, 1'b1, 1'b1, 2'b11, 1'b0},
    {16'h0000, 2'b00, 1'b1, 1'b0, 2'b00, 1'b0},
    {16'h0103, 2'b00, 1'b1, 1'b1, 2'b01, 1'b0},
    {16'h0103, 2'b11, 1'b1, 1'b0, 2'b10, 1'b0},
    {16'h0103, 2'b01, 1'b0, 1'b1, 2'b01, 1'b0},
    {16'h0103, 2'b00, 1'b0, 1'b1, 2'b00, 1'b1},
    {16'h0103, 2'b11, 1'b0, 1'b1, 2'b11, 1'b1},
    {16'h0103, 2'b10, 1'b0, 1'b0, 2'b10, 1'b0},
    {16'hFFFF, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0},
    {16'hFF7F, 2'b00, 1'b0, 1'b1, 2'b00, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_ab();
    #2; clk_ab = 1'b1; #2; clk_ab = 1'b0; #2;
  endtask

  task automatic pulse_ba();
    #2; clk_ba = 1'b1; #2; clk_ba = 1'b0; #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; odd_sel = 1'b1;
    clk_ab = 1'b0; le_ab = 1'b0; oe_ab = 1'b0; gen_sel = 1'b0;
    clk_ba = 1'b0; le_ba = 1'b0; oe_ba = 1'b0;
    a_in = 16'h5A5A; a_par_in = 2'b11; b_in = 16'hA5A5; b_par_in = 2'b11;
    #20;
    check(b_oe == 0 && b_out == 0 && b_par_out == 0 && err_ab_pull == 0, "R7 reset AB released", {b_oe, b_out}, 0);
    check(a_oe == 0 && a_out == 0 && err_ba_pull == 0, "R7 reset BA released", {a_oe, a_out}, 0);
    rst_n = 1'b1; #5;
    oe_ab = 1'b1; oe_ba = 1'b1; #2;
    check(b_out == 16'h0000 && b_par_out == 2'b00, "R8 AB stage cleared", {b_out, b_par_out}, 0);
    check(a_out == 16'h0000 && a_par_out == 2'b00, "R8 BA stage cleared", {a_out, a_par_out}, 0);

    le_ab = 1'b1;
    for (int k = 0; k < 10; k++) begin
      {a_in, a_par_in, gen_sel, odd_sel} = VEC[k][22:3];
      #2;
      check(b_out == a_in, $sformatf("R1 vec %0d data", k), b_out, a_in);
      check(b_par_out == VEC[k][2:1], $sformatf("R3/R4 vec %0d parity", k), b_par_out, VEC[k][2:1]);
      check(err_ab_pull == VEC[k][0], $sformatf("R3/R4 vec %0d flag", k), err_ab_pull, VEC[k][0]);
    end

    // R2 clocked capture then hold
    le_ab = 1'b0; gen_sel = 1'b0; odd_sel = 1'b1;
    a_in = 16'h1234; a_par_in = 2'b10;
    pulse_ab();
    check(b_out == 16'h1234 && b_par_out == 2'b10, "R2 captured", {b_out, b_par_out}, {16'h1234, 2'b10});
    a_in = 16'h5678; a_par_in = 2'b01; #3;
    check(b_out == 16'h1234 && b_par_out == 2'b10, "R2 hold while idle", {b_out, b_par_out}, {16'h1234, 2'b10});

    // R9 independence
    le_ba = 1'b0; b_in = 16'hABCD; b_par_in = 2'b01;
    pulse_ba();
    check(a_out == 16'hABCD && a_par_out == 2'b01, "R2 BA captured", {a_out, a_par_out}, {16'hABCD, 2'b01});
    check(b_out == 16'h1234, "R9 AB kept after BA clock", b_out, 16'h1234);
    b_in = 16'h0F0F;
    pulse_ab();
    check(a_out == 16'hABCD, "R9 BA kept after AB clock", a_out, 16'hABCD);

    // R5 BA check-only
    le_ba = 1'b1; odd_sel = 1'b1;
    b_in = 16'h0001; b_par_in = 2'b00; #2;
    check(err_ba_pull == 1'b1 && a_par_out == 2'b00, "R5 BA byte1 mismatch", {err_ba_pull, a_par_out}, 3'b100);
    b_par_in = 2'b10; #2;
    check(err_ba_pull == 1'b0 && a_par_out == 2'b10, "R5 BA parity ok", {err_ba_pull, a_par_out}, 3'b010);

    // R6 shared sense
    le_ab = 1'b1; gen_sel = 1'b0; a_in = 16'h0000; a_par_in = 2'b00;
    odd_sel = 1'b0; #2;
    check(err_ab_pull == 0 && err_ba_pull == 1, "R6 even sense", {err_ab_pull, err_ba_pull}, 2'b01);
    odd_sel = 1'b1; #2;
    check(err_ab_pull == 1 && err_ba_pull == 0, "R6 odd sense", {err_ab_pull, err_ba_pull}, 2'b10);

    // R7 release masks flag
    oe_ab = 1'b0; #2;
    check(err_ab_pull == 0 && b_oe == 0 && b_out == 0 && b_par_out == 0, "R7 AB disabled", {err_ab_pull, b_oe, b_out}, 0);
    b_par_in = 2'b00; oe_ba = 1'b0; #2;
    check(err_ba_pull == 0 && a_oe == 0 && a_out == 0, "R7 BA disabled", {err_ba_pull, a_oe, a_out}, 0);
    oe_ba = 1'b1; #2;
    check(err_ba_pull == 1, "R5 BA flag back when enabled", err_ba_pull, 1);

    // R8 reset clears stored words
    le_ab = 1'b0; le_ba = 1'b0; oe_ab = 1'b1;
    rst_n = 1'b0; #3; rst_n = 1'b1; #2;
    check(b_out == 0 && a_out == 0, "R8 reset clears both stages", {b_out, a_out}, 0);

    #10;
    finish_run();
  end
endmodule